// File: doc/BRIEF.md
# Two-Level Event Interrupt Controller

This block folds the event flags of a random-number generator core into a single level interrupt. Three sticky first-level flags record a finished generation, a failed deterministic self-test and a failed entropy-health test. Each flag has an enable and a write-one clear bit, both in one control word. When any flag is set together with its enable, a core-interrupt bit in a second-level status word is raised.

The second level holds that core-interrupt bit and a bus-error bit, both cleared by writing ones. A mask, which comes out of reset fully masked, is opened and closed through two separate write ports. The interrupt line is high while any unmasked second-level bit is set. Fault events are accepted only while the entropy source is running. A legacy build option also requires the health-test unit to be switched on before a health failure is accepted. Register writes arrive as a select code plus a 32-bit data word. Address decode and the generator itself sit outside the block.

Top module: `rng_irq_ctrl`

## Requirements
- R1: After reset the enables, the first-level flags and the second-level status are all zero, the mask is 2'b11 and `irq` is low.
- R2: A write with `wr_sel`=0 loads `core_en` from data bits 2:0 (bit0 done, bit1 test failure, bit2 health failure). Data bits 3, 4 and 5 set to one clear the done, test-failure and health-failure flags. These flags appear in `core_stat` at bits 0, 1 and 3, and bit 2 reads zero.
- R3: An `ev_done` pulse sets `core_stat[0]` at the next clock edge, and the flag stays set until it is cleared.
- R4: `ev_test_fail` and `ev_health_fail` are ignored unless `src_in_reset`=0, `src_en`=1 and `osc_en`=1.
- R5: When LEGACY_HW=1, `ev_health_fail` is also ignored unless `health_unit_en`=1. When LEGACY_HW=0, that input has no effect.
- R6: On every core update (a control write, an accepted event or a soft reset), `top_stat[0]` takes the OR of the enabled flags. A write with `wr_sel`=1 and data bit 0 set clears it in a cycle that has no core update.
- R7: `ev_bus_err` sets `top_stat[1]`. A write with `wr_sel`=1 and data bit 1 set clears it, unless a bus-error event arrives in the same cycle.
- R8: A write with `wr_sel`=2 clears the `mask` bits where the data has ones. A write with `wr_sel`=3 sets them.
- R9: `irq` is a register output. After every edge it equals the OR of `top_stat & ~mask`.
- R10: `soft_rst` clears all first-level flags and `top_stat[0]` at the same edge and overrides events in that cycle. Enables, mask and `top_stat[1]` are kept.
- R11: If a first-level event arrives in the same cycle as a write of its clear bit, the flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 second-level status, 2 unmask, 3 mask |
| wr_data | input | 32 | Write data |
| soft_rst | input | 1 | Generator soft reset pulse |
| ev_done | input | 1 | Generation finished pulse |
| ev_test_fail | input | 1 | Deterministic test failure pulse |
| ev_health_fail | input | 1 | Entropy-health failure pulse |
| ev_bus_err | input | 1 | Bus error pulse |
| src_in_reset | input | 1 | Entropy source held in reset |
| src_en | input | 1 | Entropy source enabled |
| osc_en | input | 1 | Oscillator enabled |
| health_unit_en | input | 1 | Health-test unit enabled (legacy build only) |
| core_en | output | 3 | First-level enables |
| core_stat | output | 4 | First-level flags (bits 0, 1, 3) |
| top_stat | output | 2 | Second-level status: core interrupt, bus error |
| mask | output | 2 | Second-level mask |
| irq | output | 1 | Level interrupt |

## Verification
Two kinds of collision can happen in one cycle. An event can meet the write-one clear that targets the same flag, and this happens at both levels: a test failure with its control clear bit, and a bus error with its status clear bit. A soft reset can also meet a done event. The bench drives each pair on the same falling edge so that both are sampled at one rising edge. The expected result is that the event survives the clear, while the soft reset wins over the event. These outcomes are checked on `core_stat` and `top_stat`. The bench also repeats each clear on its own to show that the clear path works by itself.

// File: rtl/rng_irq_pkg.sv
package rng_irq_pkg;
  localparam int NUM_CORE = 3;
  localparam int TOP_W    = 2;
  localparam int CLR_LSB  = NUM_CORE;
  localparam int CTRL_W   = 2 * NUM_CORE;

  typedef enum logic [1:0] {
    SEL_CORE_CTRL = 2'd0,
    SEL_TOP_STAT  = 2'd1,
    SEL_UNMASK    = 2'd2,
    SEL_MASK      = 2'd3
  } wsel_e;

  function automatic logic core_pending(input logic [NUM_CORE-1:0] fl,
                                        input logic [NUM_CORE-1:0] en);
    return |(fl & en);
  endfunction

  function automatic logic [3:0] pack_core(input logic [NUM_CORE-1:0] fl);
    return {fl[2], 1'b0, fl[1:0]};
  endfunction

  function automatic logic [TOP_W-1:0] apply_mask_wr(input logic [TOP_W-1:0] cur,
                                                     input logic open_wr,
                                                     input logic close_wr,
                                                     input logic [TOP_W-1:0] bits);
    if (open_wr)  return cur & ~bits;
    if (close_wr) return cur | bits;
    return cur;
  endfunction
endpackage

// File: rtl/rng_fault_gate.sv
module rng_fault_gate #(
  parameter bit LEGACY_HW = 1'b0
) (
  input  logic ev_done,
  input  logic ev_test_fail,
  input  logic ev_health_fail,
  input  logic src_in_reset,
  input  logic src_en,
  input  logic osc_en,
  input  logic health_unit_en,
  output logic gate_open,
  output logic [2:0] evt_ok
);
  logic health_ok;

  assign gate_open = !src_in_reset && src_en && osc_en;

  generate
    if (LEGACY_HW) begin : g_legacy
      assign health_ok = gate_open && health_unit_en;
    end else begin : g_current
      logic unused_unit_en;
      assign unused_unit_en = health_unit_en;
      assign health_ok = gate_open;
    end
  endgenerate

  assign evt_ok = {ev_health_fail && health_ok, ev_test_fail && gate_open, ev_done};
endmodule

// File: rtl/rng_core_flags.sv
module rng_core_flags
  import rng_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic [NUM_CORE-1:0] evt_ok,
  output logic [NUM_CORE-1:0] en_q,
  output logic [NUM_CORE-1:0] flag_q,
  output logic core_update,
  output logic pending_next
);
  logic [NUM_CORE-1:0] flag_d;
  logic [NUM_CORE-1:0] en_d;
  logic [NUM_CORE-1:0] clr_req;

  assign clr_req = ctrl_wr ? ctrl_data[CLR_LSB +: NUM_CORE] : '0;
  assign en_d    = ctrl_wr ? ctrl_data[NUM_CORE-1:0] : en_q;

  genvar i;
  generate
    for (i = 0; i < NUM_CORE; i++) begin : g_flag
      assign flag_d[i] = soft_rst ? 1'b0 : (evt_ok[i] | (flag_q[i] & ~clr_req[i]));
    end
  endgenerate

  assign core_update  = ctrl_wr | (|evt_ok) | soft_rst;
  assign pending_next = soft_rst ? 1'b0 : core_pending(flag_d, en_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/rng_top_level.sv
module rng_top_level
  import rng_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic core_update,
  input  logic pending_next,
  input  logic ev_bus_err,
  input  logic stat_wr,
  input  logic open_wr,
  input  logic close_wr,
  input  logic [TOP_W-1:0] wbits,
  output logic [TOP_W-1:0] stat_q,
  output logic [TOP_W-1:0] mask_q,
  output logic irq_q
);
  logic [TOP_W-1:0] stat_d;
  logic [TOP_W-1:0] mask_d;
  logic [TOP_W-1:0] w1c;

  assign w1c = stat_wr ? wbits : '0;

  always_comb begin
    stat_d[0] = core_update ? pending_next : (stat_q[0] & ~w1c[0]);
    stat_d[1] = ev_bus_err | (stat_q[1] & ~w1c[1]);
  end

  assign mask_d = apply_mask_wr(mask_q, open_wr, close_wr, wbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= |(stat_d & ~mask_d);
    end
  end
endmodule

// File: rtl/rng_irq_ctrl.sv
module rng_irq_ctrl
  import rng_irq_pkg::*;
#(
  parameter bit LEGACY_HW = 1'b0,
  parameter int DATA_W    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic [1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic soft_rst,
  input  logic ev_done,
  input  logic ev_test_fail,
  input  logic ev_health_fail,
  input  logic ev_bus_err,
  input  logic src_in_reset,
  input  logic src_en,
  input  logic osc_en,
  input  logic health_unit_en,
  output logic [NUM_CORE-1:0] core_en,
  output logic [3:0] core_stat,
  output logic [TOP_W-1:0] top_stat,
  output logic [TOP_W-1:0] mask,
  output logic irq
);
  logic ctrl_wr, stat_wr, open_wr, close_wr;
  logic gate_open;
  logic core_update, pending_next;
  logic [NUM_CORE-1:0] evt_ok;
  logic [NUM_CORE-1:0] flag_q;
  logic unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CTRL_W];
  assign ctrl_wr  = wr_en && (wr_sel == SEL_CORE_CTRL);
  assign stat_wr  = wr_en && (wr_sel == SEL_TOP_STAT);
  assign open_wr  = wr_en && (wr_sel == SEL_UNMASK);
  assign close_wr = wr_en && (wr_sel == SEL_MASK);

  rng_fault_gate #(.LEGACY_HW(LEGACY_HW)) u_gate (
    .ev_done(ev_done), .ev_test_fail(ev_test_fail), .ev_health_fail(ev_health_fail),
    .src_in_reset(src_in_reset), .src_en(src_en), .osc_en(osc_en),
    .health_unit_en(health_unit_en), .gate_open(gate_open), .evt_ok(evt_ok)
  );

  rng_core_flags u_core (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctrl_wr(ctrl_wr),
    .ctrl_data(wr_data[CTRL_W-1:0]), .evt_ok(evt_ok), .en_q(core_en),
    .flag_q(flag_q), .core_update(core_update), .pending_next(pending_next)
  );

  rng_top_level u_top (
    .clk(clk), .rst_n(rst_n), .core_update(core_update), .pending_next(pending_next),
    .ev_bus_err(ev_bus_err), .stat_wr(stat_wr), .open_wr(open_wr), .close_wr(close_wr),
    .wbits(wr_data[TOP_W-1:0]), .stat_q(top_stat), .mask_q(mask), .irq_q(irq)
  );

  assign core_stat = pack_core(flag_q);
endmodule

// File: rtl/rng_irq_chk.sv
module rng_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic ev_done,
  input logic ev_test_fail,
  input logic ev_bus_err,
  input logic gate_open,
  input logic close_wr,
  input logic [31:0] wr_data,
  input logic [3:0] core_stat,
  input logic [1:0] top_stat,
  input logic [1:0] mask,
  input logic irq
);
  // R9: registered line agrees with status and mask
  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(top_stat & ~mask));

  // R3: done pulse lands in the first-level flag
  p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !soft_rst) |=> core_stat[0]);

  // R4: closed gate keeps a clear test flag clear
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stat[1] && !(ev_test_fail && gate_open)) |=> !core_stat[1]);

  // R10: soft reset empties the first level and core bit
  p_soft_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (core_stat == 4'b0000) && !top_stat[0]);

  // R7: bus error always lands
  p_bus_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> top_stat[1]);

  // R8: closing the mask sets the bit
  p_mask_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (close_wr && wr_data[0]) |=> mask[0]);
endmodule

bind rng_irq_ctrl rng_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev_done(ev_done),
  .ev_test_fail(ev_test_fail), .ev_bus_err(ev_bus_err), .gate_open(gate_open),
  .close_wr(close_wr), .wr_data(wr_data), .core_stat(core_stat),
  .top_stat(top_stat), .mask(mask), .irq(irq)
);

// File: tb/rng_irq_ctrl_tb.sv
module rng_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic soft_rst = 1'b0, ev_done = 1'b0, ev_test_fail = 1'b0;
  logic ev_health_fail = 1'b0, ev_bus_err = 1'b0;
  logic src_in_reset = 1'b0, src_en = 1'b1, osc_en = 1'b1, health_unit_en = 1'b0;
  logic [2:0] core_en, core_en_l;
  logic [3:0] core_stat, core_stat_l;
  logic [1:0] top_stat, top_stat_l, mask, mask_l;
  logic irq, irq_l;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rng_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .soft_rst(soft_rst), .ev_done(ev_done), .ev_test_fail(ev_test_fail),
    .ev_health_fail(ev_health_fail), .ev_bus_err(ev_bus_err),
    .src_in_reset(src_in_reset), .src_en(src_en), .osc_en(osc_en),
    .health_unit_en(health_unit_en), .core_en(core_en), .core_stat(core_stat),
    .top_stat(top_stat), .mask(mask), .irq(irq)
  );

  rng_irq_ctrl #(.LEGACY_HW(1'b1)) u_dut_legacy (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .soft_rst(soft_rst), .ev_done(ev_done), .ev_test_fail(ev_test_fail),
    .ev_health_fail(ev_health_fail), .ev_bus_err(ev_bus_err),
    .src_in_reset(src_in_reset), .src_en(src_en), .osc_en(osc_en),
    .health_unit_en(health_unit_en), .core_en(core_en_l), .core_stat(core_stat_l),
    .top_stat(top_stat_l), .mask(mask_l), .irq(irq_l)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [3:0] cs, input logic [1:0] ts,
                         input logic [1:0] mk, input logic iq);
    chk({tag, " core_stat"}, 32'(core_stat), 32'(cs));
    chk({tag, " top_stat"}, 32'(top_stat), 32'(ts));
    chk({tag, " mask"}, 32'(mask), 32'(mk));
    chk({tag, " irq"}, 32'(irq), 32'(iq));
  endtask

  // one cycle of stimulus: drive on falling edge, release on next falling edge
  task automatic cyc(input logic we, input logic [1:0] sel, input logic [31:0] d,
                     input logic [4:0] ev);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d;
    {soft_rst, ev_bus_err, ev_health_fail, ev_test_fail, ev_done} = ev;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    {soft_rst, ev_bus_err, ev_health_fail, ev_test_fail, ev_done} = '0;
  endtask

  task automatic t_reset;
    chk("R1 core_en", 32'(core_en), 0);
    chk_all("R1", 4'b0000, 2'b00, 2'b11, 1'b0);
  endtask

  task automatic t_done_and_enable;
    cyc(0, 0, 0, 5'b00001);
    chk_all("R3 done unenabled", 4'b0001, 2'b00, 2'b11, 1'b0);
    cyc(1, 0, 32'h1, 0);
    chk("R2 enable load", 32'(core_en), 32'h1);
    chk_all("R6 core bit", 4'b0001, 2'b01, 2'b11, 1'b0);
    cyc(1, 2, 32'h1, 0);
    chk_all("R8 R9 unmask core", 4'b0001, 2'b01, 2'b10, 1'b1);
    cyc(1, 0, 32'h9, 0);
    chk_all("R2 clear done", 4'b0000, 2'b00, 2'b10, 1'b0);
  endtask

  task automatic t_gate;
    src_en = 1'b0;
    cyc(0, 0, 0, 5'b00010);
    chk("R4 src_en low", 32'(core_stat), 0);
    src_en = 1'b1; osc_en = 1'b0;
    cyc(0, 0, 0, 5'b00010);
    chk("R4 osc_en low", 32'(core_stat), 0);
    osc_en = 1'b1; src_in_reset = 1'b1;
    cyc(0, 0, 0, 5'b00010);
    chk("R4 in reset", 32'(core_stat), 0);
    src_in_reset = 1'b0;
    cyc(0, 0, 0, 5'b00010);
    chk_all("R4 gate open", 4'b0010, 2'b00, 2'b10, 1'b0);
  endtask

  task automatic t_legacy;
    cyc(0, 0, 0, 5'b00100);
    chk("R5 current ignores unit enable", 32'(core_stat), 32'hA);
    chk("R5 legacy blocked", 32'(core_stat_l), 32'h2);
    health_unit_en = 1'b1;
    cyc(0, 0, 0, 5'b00100);
    chk("R5 legacy accepted", 32'(core_stat_l), 32'hA);
    chk("R5 current unchanged", 32'(core_stat), 32'hA);
  endtask

  task automatic t_top_w1c;
    cyc(1, 0, 32'h2, 0);
    chk_all("R6 test enabled", 4'b1010, 2'b01, 2'b10, 1'b1);
    cyc(1, 1, 32'h1, 0);
    chk_all("R6 w1c core bit", 4'b1010, 2'b00, 2'b10, 1'b0);
  endtask

  task automatic t_clear_collide;
    cyc(1, 0, 32'h12, 5'b00010);
    chk_all("R11 event beats clear", 4'b1010, 2'b01, 2'b10, 1'b1);
    cyc(1, 0, 32'h12, 0);
    chk_all("R2 clear test alone", 4'b1000, 2'b00, 2'b10, 1'b0);
    cyc(1, 0, 32'h22, 0);
    chk_all("R2 clear health", 4'b0000, 2'b00, 2'b10, 1'b0);
  endtask

  task automatic t_bus_err;
    cyc(0, 0, 0, 5'b01000);
    chk_all("R7 bus err masked", 4'b0000, 2'b10, 2'b10, 1'b0);
    cyc(1, 2, 32'h2, 0);
    chk_all("R8 unmask bus err", 4'b0000, 2'b10, 2'b00, 1'b1);
    cyc(1, 1, 32'h2, 5'b01000);
    chk_all("R7 event beats w1c", 4'b0000, 2'b10, 2'b00, 1'b1);
    cyc(1, 1, 32'h2, 0);
    chk_all("R7 w1c alone", 4'b0000, 2'b00, 2'b00, 1'b0);
    cyc(0, 0, 0, 5'b01000);
    chk_all("R9 bus err raises irq", 4'b0000, 2'b10, 2'b00, 1'b1);
    cyc(1, 3, 32'h3, 0);
    chk_all("R8 close mask", 4'b0000, 2'b10, 2'b11, 1'b0);
  endtask

  task automatic t_soft_rst;
    cyc(1, 0, 32'h1, 0);
    cyc(0, 0, 0, 5'b00001);
    chk_all("R10 setup", 4'b0001, 2'b11, 2'b11, 1'b0);
    cyc(0, 0, 0, 5'b10001);
    chk_all("R10 soft reset", 4'b0000, 2'b10, 2'b11, 1'b0);
    chk("R10 enables kept", 32'(core_en), 32'h1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_done_and_enable();
    t_gate();
    t_legacy();
    t_top_w1c();
    t_clear_collide();
    t_bus_err();
    t_soft_rst();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule